// File: doc/BRIEF.md
# I2C Byte Buffer Handshake Unit

This unit sits between a host register port and the bit-serial side of an I2C controller. It holds one data byte for the host, a shift register for the wire, a few control and status bits, and two interrupt flags. In transmit mode the host places a byte in the buffer and arms a transfer. The unit then sends the byte MSB first, samples the receiver's acknowledge and reports that the buffer is empty. In receive mode the unit shifts a byte in, drives the acknowledge level the host chose, and reports that the buffer is full once the acknowledge bit has ended.

Between bytes the unit holds SCL low (wait states) until the host has done its part. In transmit mode the host must write the buffer and arm the transfer. In receive mode the host must read the buffer and arm the transfer. Buffer moves and interrupt flags are tied to the end of the acknowledge bit, not to the end of the eighth data bit. A detected STOP releases the hold and returns the unit to idle. Master and slave roles behave alike here: SCL edges, START and STOP arrive as strobes from the surrounding controller. A bus-monitor register shows the SCL and SDA pin levels.

Top module: `i2c_bytebuf_hs`

## Requirements
- R1: Register 0 holds the 8-bit data byte in bits 7:0. Bits 31:8 read as zero. After reset, registers 0, 1 and 2 read 0x00.
- R2: In transmit mode (tx_mode=1) the shift register loads from the buffer only when both of these hold: the transfer bit (register 1 bit 0) is set, and the buffer has been written since the last load. Bits leave MSB first on sda_drive. The level changes only on an SCL fall strobe.
- R3: In transmit mode the transmit-empty flag (register 2 bit 0) is set on the SCL fall that ends the ninth (acknowledge) bit, and only if its enable (register 1 bit 2) is 1. A NAK still completes the byte.
- R4: In transmit mode scl_hold is 1 after a START and after every completed byte. It stays 1 until the buffer is written and the transfer bit is set.
- R5: In receive mode SDA is sampled MSB first on SCL rise strobes. The received byte reaches register 0 only when the acknowledge bit ends. The receive-full flag (register 2 bit 1) is then set if its enable (register 1 bit 3) is 1.
- R6: In receive mode scl_hold stays 1 after a completed byte until the buffer has been read and the transfer bit has been set. During the acknowledge bit, sda_drive equals the ACK/NAK control bit (register 1 bit 1: 0 = ACK, driven low; 1 = NAK, released). It is 1 during the data bits.
- R7: In transmit mode the SDA level at the ninth SCL rise is stored in register 2 bit 2 (1 = NAK received).
- R8: The transfer bit clears itself when a byte transfer begins. Writing 1 to a flag bit of register 2 clears that flag. A flag set in the same cycle as its clear stays set.
- R9: A STOP strobe releases scl_hold and returns the unit to idle. Register 2 bit 3 (busy) then reads 0, and no buffer flag is raised.
- R10: Register 3 shows the SDA pin in bit 0 and the SCL pin in bit 1, one clock after the pin level. Bits 31:2 read zero, and both bits reset to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe (a read of register 0 marks the buffer consumed) |
| reg_addr | input | 2 | Register select: 0 data, 1 control, 2 status, 3 bus monitor |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data (combinational) |
| tx_mode | input | 1 | 1 = transmit, 0 = receive |
| scl_rise | input | 1 | One-cycle strobe on an SCL rising edge |
| scl_fall | input | 1 | One-cycle strobe on an SCL falling edge |
| sda_in | input | 1 | Sampled SDA level |
| start_det | input | 1 | START (or repeated START) detected |
| stop_det | input | 1 | STOP detected |
| scl_pin | input | 1 | Raw SCL pin level for the monitor |
| sda_pin | input | 1 | Raw SDA pin level for the monitor |
| sda_drive | output | 1 | SDA output level (0 = drive low, 1 = release) |
| scl_hold | output | 1 | Request to hold SCL low |
| irq | output | 1 | OR of the two buffer flags |

## Verification
The SCL fall that ends an acknowledge bit can set a buffer flag in the same clock cycle as a host write-one-to-clear of that flag. The bench provokes this by sending the acknowledge-end fall strobe and the clearing write to register 2 together. The flag must then read 1 afterwards. The bench also mixes, on a fixed seed, random bytes, directions, enables and acknowledge levels with directed stalls. It judges hold release, bit order and flag values against its own model of the byte sequence.

// File: rtl/i2c_bb_pkg.sv
package i2c_bb_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_SHIFT, ST_ACK} eng_state_e;

  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_CTRL = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;
  localparam logic [1:0] A_MON  = 2'd3;

  localparam int CTL_XFER = 0;
  localparam int CTL_NAK  = 1;
  localparam int CTL_TXIE = 2;
  localparam int CTL_RXIE = 3;

  localparam int STA_TXE  = 0;
  localparam int STA_RXF  = 1;
  localparam int STA_NAKR = 2;
  localparam int STA_BUSY = 3;

  // a byte slot may start once the host has done its half of the handshake
  function automatic logic slot_ready(input logic tx, input logic xfer,
                                      input logic wr_pend, input logic rd_done);
    return xfer && (tx ? wr_pend : rd_done);
  endfunction

  // write-one-to-clear flag: a set in the same cycle wins
  function automatic logic w1c_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/i2c_bb_engine.sv
module i2c_bb_engine
  import i2c_bb_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_mode,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_in,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          xfer,
  input  logic          wr_pend,
  input  logic          rd_done,
  input  logic          nak_ctl,
  input  logic [DW-1:0] buf_q,
  output logic          sda_drive,
  output logic          scl_hold,
  output logic          busy,
  output logic          byte_go,
  output logic          byte_done,
  output logic          ack_sample,
  output logic [DW-1:0] rx_byte
);
  localparam int CW = $clog2(DW + 2);
  localparam logic [CW-1:0] LAST_DATA = CW'(DW);
  localparam logic [CW-1:0] ACK_CNT   = CW'(DW + 1);

  eng_state_e    state;
  logic [CW-1:0] cnt;
  logic [DW-1:0] shreg;
  logic          no_cond;

  assign no_cond    = !stop_det && !start_det;
  assign byte_go    = (state == ST_WAIT) && no_cond &&
                      slot_ready(tx_mode, xfer, wr_pend, rd_done);
  assign ack_sample = (state == ST_ACK) && scl_rise && tx_mode && no_cond;
  assign byte_done  = (state == ST_ACK) && scl_fall && (cnt == ACK_CNT) && no_cond;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      shreg <= '0;
    end else if (stop_det) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else if (start_det) begin
      state <= ST_WAIT;
      cnt   <= '0;
    end else begin
      case (state)
        ST_WAIT: if (byte_go) begin
          state <= ST_SHIFT;
          cnt   <= '0;
          shreg <= tx_mode ? buf_q : '0;
        end
        ST_SHIFT: begin
          if (scl_rise) begin
            cnt <= cnt + 1'b1;
            if (!tx_mode) shreg <= {shreg[DW-2:0], sda_in};
          end else if (scl_fall && cnt != '0) begin
            if (cnt == LAST_DATA) state <= ST_ACK;
            else if (tx_mode)     shreg <= {shreg[DW-2:0], 1'b0};
          end
        end
        ST_ACK: begin
          if (scl_rise) cnt <= cnt + 1'b1;
          else if (byte_done) begin
            state <= ST_WAIT;
            cnt   <= '0;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    sda_drive = 1'b1;
    if (state == ST_SHIFT && tx_mode)    sda_drive = shreg[DW-1];
    else if (state == ST_ACK && !tx_mode) sda_drive = nak_ctl;
  end

  assign scl_hold = (state == ST_WAIT);
  assign busy     = (state != ST_IDLE);
  assign rx_byte  = shreg;

endmodule

// File: rtl/i2c_bb_regs.sv
module i2c_bb_regs
  import i2c_bb_pkg::*;
#(
  parameter int DW    = 8,
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [1:0]       reg_addr,
  input  logic [BUS_W-1:0] reg_wdata,
  output logic [BUS_W-1:0] reg_rdata,
  input  logic             tx_mode,
  input  logic             sda_in,
  input  logic             byte_go,
  input  logic             byte_done,
  input  logic             ack_sample,
  input  logic [DW-1:0]    rx_byte,
  input  logic             busy,
  input  logic             mon_scl,
  input  logic             mon_sda,
  output logic [DW-1:0]    buf_q,
  output logic             xfer,
  output logic             nak_ctl,
  output logic             txe_ie,
  output logic             rxf_ie,
  output logic             wr_pend,
  output logic             rd_done,
  output logic             txe_f,
  output logic             rxf_f,
  output logic             nak_rcvd
);
  logic wr_data, wr_ctrl, wr_stat, rd_data;
  logic tx_end, rx_end;
  logic unused_hi;

  assign wr_data   = reg_wr && reg_addr == A_DATA;
  assign wr_ctrl   = reg_wr && reg_addr == A_CTRL;
  assign wr_stat   = reg_wr && reg_addr == A_STAT;
  assign rd_data   = reg_rd && reg_addr == A_DATA;
  assign tx_end    = byte_done && tx_mode;
  assign rx_end    = byte_done && !tx_mode;
  assign unused_hi = ^reg_wdata[BUS_W-1:DW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q    <= '0;
      xfer     <= 1'b0;
      nak_ctl  <= 1'b0;
      txe_ie   <= 1'b0;
      rxf_ie   <= 1'b0;
      wr_pend  <= 1'b0;
      rd_done  <= 1'b1;
      txe_f    <= 1'b0;
      rxf_f    <= 1'b0;
      nak_rcvd <= 1'b0;
    end else begin
      // host side first; engine events below take precedence
      if (wr_data) begin
        buf_q   <= reg_wdata[DW-1:0];
        wr_pend <= 1'b1;
      end
      if (rd_data) rd_done <= 1'b1;
      if (wr_ctrl) begin
        xfer    <= reg_wdata[CTL_XFER];
        nak_ctl <= reg_wdata[CTL_NAK];
        txe_ie  <= reg_wdata[CTL_TXIE];
        rxf_ie  <= reg_wdata[CTL_RXIE];
      end
      if (byte_go) begin
        xfer <= 1'b0;
        if (tx_mode) wr_pend <= 1'b0;
      end
      if (rx_end) begin
        buf_q   <= rx_byte;
        rd_done <= 1'b0;
      end
      if (ack_sample) nak_rcvd <= sda_in;
      txe_f <= w1c_next(txe_f, tx_end && txe_ie, wr_stat && reg_wdata[STA_TXE]);
      rxf_f <= w1c_next(rxf_f, rx_end && rxf_ie, wr_stat && reg_wdata[STA_RXF]);
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_DATA: reg_rdata[DW-1:0] = buf_q;
      A_CTRL: begin
        reg_rdata[CTL_XFER] = xfer;
        reg_rdata[CTL_NAK]  = nak_ctl;
        reg_rdata[CTL_TXIE] = txe_ie;
        reg_rdata[CTL_RXIE] = rxf_ie;
      end
      A_STAT: begin
        reg_rdata[STA_TXE]  = txe_f;
        reg_rdata[STA_RXF]  = rxf_f;
        reg_rdata[STA_NAKR] = nak_rcvd;
        reg_rdata[STA_BUSY] = busy;
      end
      default: reg_rdata[1:0] = {mon_scl, mon_sda};
    endcase
  end

endmodule

// File: rtl/i2c_bb_busmon.sv
module i2c_bb_busmon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_pin,
  input  logic sda_pin,
  output logic mon_scl,
  output logic mon_sda
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mon_scl <= 1'b1;
      mon_sda <= 1'b1;
    end else begin
      mon_scl <= scl_pin;
      mon_sda <= sda_pin;
    end
  end
endmodule

// File: rtl/i2c_bytebuf_hs.sv
module i2c_bytebuf_hs
  import i2c_bb_pkg::*;
#(
  parameter int DW    = 8,
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [1:0]       reg_addr,
  input  logic [BUS_W-1:0] reg_wdata,
  output logic [BUS_W-1:0] reg_rdata,
  input  logic             tx_mode,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             sda_in,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic             scl_pin,
  input  logic             sda_pin,
  output logic             sda_drive,
  output logic             scl_hold,
  output logic             irq
);
  logic [DW-1:0] buf_q, rx_byte;
  logic xfer, nak_ctl, txe_ie, rxf_ie, wr_pend, rd_done;
  logic txe_f, rxf_f, nak_rcvd, busy;
  logic byte_go, byte_done, ack_sample;
  logic mon_scl, mon_sda;

  i2c_bb_engine #(.DW(DW)) u_eng (
    .clk(clk), .rst_n(rst_n), .tx_mode(tx_mode),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_in(sda_in),
    .start_det(start_det), .stop_det(stop_det),
    .xfer(xfer), .wr_pend(wr_pend), .rd_done(rd_done),
    .nak_ctl(nak_ctl), .buf_q(buf_q),
    .sda_drive(sda_drive), .scl_hold(scl_hold), .busy(busy),
    .byte_go(byte_go), .byte_done(byte_done), .ack_sample(ack_sample),
    .rx_byte(rx_byte)
  );

  i2c_bb_regs #(.DW(DW), .BUS_W(BUS_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_mode(tx_mode), .sda_in(sda_in),
    .byte_go(byte_go), .byte_done(byte_done), .ack_sample(ack_sample),
    .rx_byte(rx_byte), .busy(busy), .mon_scl(mon_scl), .mon_sda(mon_sda),
    .buf_q(buf_q), .xfer(xfer), .nak_ctl(nak_ctl),
    .txe_ie(txe_ie), .rxf_ie(rxf_ie), .wr_pend(wr_pend), .rd_done(rd_done),
    .txe_f(txe_f), .rxf_f(rxf_f), .nak_rcvd(nak_rcvd)
  );

  i2c_bb_busmon u_mon (
    .clk(clk), .rst_n(rst_n), .scl_pin(scl_pin), .sda_pin(sda_pin),
    .mon_scl(mon_scl), .mon_sda(mon_sda)
  );

  assign irq = txe_f | rxf_f;

endmodule

// File: rtl/i2c_bb_checker.sv
module i2c_bb_checker #(
  parameter int DW    = 8,
  parameter int BUS_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       reg_addr,
  input logic [BUS_W-1:0] reg_rdata,
  input logic             tx_mode,
  input logic             sda_in,
  input logic             start_det,
  input logic             stop_det,
  input logic             scl_pin,
  input logic             sda_pin,
  input logic             sda_drive,
  input logic             scl_hold,
  input logic             byte_go,
  input logic             byte_done,
  input logic             ack_sample,
  input logic [DW-1:0]    buf_q,
  input logic             xfer,
  input logic             rd_done,
  input logic             rxf_ie,
  input logic             txe_f,
  input logic             rxf_f,
  input logic             nak_rcvd,
  input logic             busy,
  input logic             mon_scl,
  input logic             mon_sda
);
  AST_DATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd0) |-> (reg_rdata[BUS_W-1:DW] == '0)); // R1
  AST_TX_LOAD_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_go && tx_mode) |=> (sda_drive == $past(buf_q[DW-1]))); // R2
  AST_TXE_AT_BYTE_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txe_f) |-> $past(byte_done && tx_mode)); // R3
  AST_HOLD_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !stop_det && !start_det) |=> scl_hold); // R4
  AST_RXF_AT_ACK_END: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !tx_mode && rxf_ie) |=> rxf_f); // R5
  AST_RX_WAIT_FOR_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_hold && !rd_done && !tx_mode && !stop_det && !start_det) |=> scl_hold); // R6
  AST_NAK_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_sample |=> (nak_rcvd == $past(sda_in))); // R7
  AST_XFER_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    byte_go |=> !xfer); // R8
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!scl_hold && !busy)); // R9
  AST_MON_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ({mon_scl, mon_sda} == $past({scl_pin, sda_pin}))); // R10
endmodule

bind i2c_bytebuf_hs i2c_bb_checker #(.DW(DW), .BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .tx_mode(tx_mode), .sda_in(sda_in), .start_det(start_det), .stop_det(stop_det),
  .scl_pin(scl_pin), .sda_pin(sda_pin), .sda_drive(sda_drive), .scl_hold(scl_hold),
  .byte_go(byte_go), .byte_done(byte_done), .ack_sample(ack_sample),
  .buf_q(buf_q), .xfer(xfer), .rd_done(rd_done), .rxf_ie(rxf_ie),
  .txe_f(txe_f), .rxf_f(rxf_f), .nak_rcvd(nak_rcvd), .busy(busy),
  .mon_scl(mon_scl), .mon_sda(mon_sda)
);

// File: tb/tb_i2c_bytebuf_hs.sv
`timescale 1ns/1ps
module tb_i2c_bytebuf_hs;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0, reg_rd = 0;
  logic [1:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic tx_mode = 1, scl_rise = 0, scl_fall = 0, sda_in = 1;
  logic start_det = 0, stop_det = 0, scl_pin = 0, sda_pin = 0;
  logic sda_drive, scl_hold, irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  i2c_bytebuf_hs dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  // one SCL strobe; optionally a write-one-to-clear of both flags in the same cycle
  task automatic scl_edge(input bit rise, input bit clr);
    @(negedge clk);
    scl_rise = rise; scl_fall = !rise;
    if (clr) begin reg_addr = 2'd2; reg_wdata = 32'h3; reg_wr = 1; end
    @(negedge clk); scl_rise = 0; scl_fall = 0; reg_wr = 0;
    tick(1);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1; @(negedge clk); s = 0; tick(1);
  endtask

  function automatic logic [31:0] ctrl_word(input bit rxie, input bit txie, input bit nak);
    return {28'd0, rxie, txie, nak, 1'b1};
  endfunction

  task automatic tx_byte(input logic [7:0] d, input bit ack, input bit ie, input bit clr_same);
    logic [31:0] r;
    tx_mode = 1;
    wr(2'd0, {24'd0, d});
    wr(2'd1, ctrl_word(0, ie, 0));
    tick(2);
    chk("R4 hold released after write+xfer", scl_hold, 0);
    rd(2'd1, r); chk("R8 xfer self-cleared", r[0], 0);
    for (int i = 7; i >= 0; i--) begin
      chk("R2 tx bit MSB first", sda_drive, d[i]);
      scl_edge(1, 0);
      chk("R2 tx bit stable across rise", sda_drive, d[i]);
      scl_edge(0, 0);
    end
    chk("R3 sda released in tx ack", sda_drive, 1);
    sda_in = ack; scl_edge(1, 0); sda_in = 1;
    scl_edge(0, clr_same);
    chk("R4 hold after tx byte", scl_hold, 1);
    rd(2'd2, r);
    chk(clr_same ? "R8 set wins over clear" : "R3 txe flag", r[0], ie);
    chk("R7 ack captured", r[2], ack);
    chk("R3 no rx flag", r[1], 0);
    wr(2'd2, 32'h3);
    rd(2'd2, r); chk("R8 w1c clears", r[1:0], 0);
  endtask

  task automatic rx_byte(input logic [7:0] d, input bit nak, input bit ie, input bit do_read);
    logic [31:0] r;
    tx_mode = 0;
    wr(2'd1, ctrl_word(ie, 0, nak));
    tick(2);
    chk("R6 hold released after read+xfer", scl_hold, 0);
    for (int i = 7; i >= 0; i--) begin
      sda_in = d[i];
      scl_edge(1, 0);
      chk("R6 sda released in rx data", sda_drive, 1);
      scl_edge(0, 0);
    end
    sda_in = 1;
    chk("R6 ack level driven", sda_drive, nak);
    scl_edge(1, 0);
    rd(2'd2, r); chk("R5 no flag before ack end", r[1], 0);
    scl_edge(0, 0);
    chk("R6 hold after rx byte", scl_hold, 1);
    rd(2'd2, r); chk("R5 rxf flag", r[1], ie);
    chk("R5 irq", irq, ie);
    if (do_read) begin
      rd(2'd0, r); chk("R5 received byte", r, {24'd0, d});
    end
    wr(2'd2, 32'h3);
  endtask

  initial begin
    logic [31:0] r;
    void'($urandom(32'd4711));
    tick(2);
    rd(2'd0, r); chk("R1 data reset", r, 0);
    rd(2'd1, r); chk("R1 ctrl reset", r, 0);
    rd(2'd2, r); chk("R1 status reset", r, 0);
    rd(2'd3, r); chk("R10 monitor reset", r, 32'h3);
    @(negedge clk); rst_n = 1;
    tick(2);
    rd(2'd3, r); chk("R10 monitor follows pins", r, 32'h0);
    pulse(start_det);
    chk("R4 hold after START", scl_hold, 1);
    wr(2'd1, ctrl_word(0, 1, 0));
    tick(3);
    chk("R4 hold kept: xfer without buffer write", scl_hold, 1);
    wr(2'd0, 32'h0000_01A5);
    rd(2'd0, r); chk("R1 upper bits zero", r, 32'hA5);
    tick(2);
    chk("R4 hold released once buffer written", scl_hold, 0);
    chk("R2 first bit", sda_drive, 1);
    scl_edge(1, 0); scl_edge(0, 0);
    chk("R2 second bit", sda_drive, 0);
    pulse(stop_det);
    chk("R9 hold released by STOP", scl_hold, 0);
    rd(2'd2, r); chk("R9 idle, no flags", r & 32'hB, 0);
    pulse(start_det);
    tx_byte(8'hA5, 0, 1, 0);
    tx_byte(8'h3C, 1, 0, 0);
    tx_byte(8'h81, 0, 1, 1);
    rx_byte(8'h5A, 0, 1, 1);
    rx_byte(8'hC3, 1, 0, 1);
    for (int k = 0; k < 16; k++) begin
      logic [7:0] d = 8'($urandom);
      bit a = 1'($urandom), ie = 1'($urandom);
      if (($urandom % 2) == 0) tx_byte(d, a, ie, 0);
      else rx_byte(d, a, ie, 1);
    end
    rx_byte(8'h96, 0, 1, 0);
    wr(2'd1, ctrl_word(1, 0, 0));
    tick(3);
    chk("R6 hold kept until buffer read", scl_hold, 1);
    rd(2'd0, r); chk("R5 held byte", r, 32'h96);
    tick(2);
    chk("R6 hold released after read", scl_hold, 0);
    scl_edge(1, 0); scl_edge(0, 0);
    pulse(stop_det);
    chk("R9 STOP mid rx byte", scl_hold, 0);
    rd(2'd2, r); chk("R9 no flag after STOP", r & 32'hB, 0);
    for (int k = 0; k < 8; k++) begin
      logic [1:0] p = 2'($urandom);
      @(negedge clk); {scl_pin, sda_pin} = p;
      tick(1);
      rd(2'd3, r); chk("R10 monitor bits", r, {30'd0, p});
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule